// File: doc/BRIEF.md
# Push-Button Power Sequencing Controller

This block decides when a system's supply is switched on and off. A user presses an active-low button to bring power up. A processor confirms that it is alive by raising a kill handshake line. Later the button, or an active-low undervoltage warning, asks for a shutdown. The controller then raises an interrupt so the processor can finish its housekeeping and lower the kill line. If the processor does not answer, keeping the request input low forces the supply off.

All timing is counted in milliseconds. The millisecond comes from a prescaler on the system clock, so a fast simulation can shrink it. Three fixed windows apply: the debounce time, the blanking time after power-up and the forced-off delay. An extra forced-off delay in milliseconds is supplied on an input bus. Two enable outputs of opposite polarity are provided, so the block can drive either a regulator enable pin or an external switch.

Top module: `pbpwr_seq`

## Requirements
- R1: While reset is asserted and after it is released, `pwr_en` is 0, `pwr_en_n` is 1 and `irq` is 0.
- R2: Power turns on (`pwr_en` becomes 1) only after `btn_n` has been low for DB_MS consecutive millisecond ticks. A high level on `btn_n` at any point before that restarts the count from zero.
- R3: `uv_n` cannot turn power on. `pwr_en` rises only in the cycle after `btn_n` was sampled low.
- R4: After power-on, a blanking window of BLANK_MS millisecond ticks runs. During it, `btn_n`, `uv_n` and `kill` have no effect: `pwr_en` stays 1 and `irq` stays 0.
- R5: If `kill` is 0 when the blanking window ends, `pwr_en` returns to 0 in the next cycle (aborted power-on).
- R6: While powered after blanking, `irq` rises when `btn_n` or `uv_n` has been low for DB_MS consecutive ticks.
- R7: After blanking, `kill` sampled 0 makes `pwr_en` 0 and `irq` 0 from the next cycle on.
- R8: Once one request source is locked, the other source is ignored while the locked input stays low. When the locked input goes high, the lock is dropped. The next source to complete a debounce is then locked, and its forced-off timer starts from zero.
- R9: If the locked input stays low, power is forced off after FORCE_MS + `xdly_ms` ticks counted from the lock.
- R10: With `xdly_ms` = 0, the forced-off delay is exactly FORCE_MS ticks.
- R11: `pwr_en_n` is always the inverse of `pwr_en`.
- R12: After any power-off, `irq` is 0. A new power-on debounce starts only after `btn_n` has been seen high. A button still held from the shutdown therefore cannot restart power.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Push button, low when pressed |
| uv_n | input | 1 | Undervoltage warning, low when the supply is weak |
| kill | input | 1 | Processor handshake; high keeps power, low shuts it off |
| xdly_ms | input | XDLY_W | Extra forced-off delay in milliseconds |
| irq | output | 1 | Shutdown request to the processor, active high |
| pwr_en | output | 1 | Power enable, active high |
| pwr_en_n | output | 1 | Power enable, active low |

## Verification
Five kinds of stimulus are used:
- Short presses and a button held through reset show whether the debounce restarts correctly and whether the release-before-rearm rule is obeyed.
- Toggling every input during blanking, with the kill line either low or high at the end, separates an aborted power-on from a completed one.
- Overlapping undervoltage and button requests show whether the lock goes to the first source and is handed over only on release.
- Held requests with a zero and a non-zero extra delay separate the fixed forced-off time from the programmable part.
- A behavioural model of all of this is compared with the outputs on every clock.

// File: rtl/pbpwr_pkg.sv
package pbpwr_pkg;

   typedef enum logic [2:0] {
      ST_REL   = 3'd0,  // off, waiting for the button to be released
      ST_ARM   = 3'd1,  // off, debouncing a power-on press
      ST_BLANK = 3'd2,  // on, handshake blanking window
      ST_ON    = 3'd3,  // on, watching for off requests
      ST_REQ   = 3'd4   // on, interrupt raised
   } pwr_state_t;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_BTN  = 2'd1,
      SRC_UV   = 2'd2
   } req_src_t;

   localparam int N_SRC   = 2;
   localparam int IDX_BTN = 0;
   localparam int IDX_UV  = 1;

endpackage

// File: rtl/pbpwr_tick.sv
module pbpwr_tick #(
   parameter int CLKS_PER_MS = 100000
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLKS_PER_MS == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_div
         localparam int TW = $clog2(CLKS_PER_MS);
         logic [TW-1:0] cnt;
         assign tick = (cnt == TW'(CLKS_PER_MS - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (tick) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pbpwr_lowdet.sv
module pbpwr_lowdet #(
   parameter int LIMIT_MS = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic enable,
   input  logic sig_n,
   output logic held
);
   localparam int CW = $clog2(LIMIT_MS + 1);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!enable || sig_n)
         cnt <= '0;
      else if (tick && cnt != CW'(LIMIT_MS))
         cnt <= cnt + 1'b1;
   end

   assign held = enable && !sig_n && (cnt == CW'(LIMIT_MS));

   // R2: a high input level restarts the low-time count
   a_r2_restart: assert property (@(posedge clk) disable iff (!rst_n)
      sig_n |=> (cnt == '0));
endmodule

// File: rtl/pbpwr_fsm.sv
module pbpwr_fsm
   import pbpwr_pkg::*;
#(
   parameter int BLANK_MS = 512,
   parameter int FORCE_MS = 64,
   parameter int XDLY_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              btn_n,
   input  logic              uv_n,
   input  logic              kill,
   input  logic [N_SRC-1:0]  held,
   input  logic [XDLY_W-1:0] xdly_ms,
   output pwr_state_t        state
);
   localparam int BW = $clog2(BLANK_MS + 1);
   localparam int FW = $clog2(FORCE_MS + (1 << XDLY_W)) + 1;

   req_src_t      src;
   logic [BW-1:0] bcnt;
   logic [FW-1:0] fcnt;
   logic [FW-1:0] flim;
   logic          src_low;

   assign flim    = FW'(FORCE_MS) + FW'(xdly_ms);
   assign src_low = (src == SRC_BTN) ? !btn_n :
                    (src == SRC_UV)  ? !uv_n  : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_REL;
         src   <= SRC_NONE;
         bcnt  <= '0;
         fcnt  <= '0;
      end else begin
         unique case (state)
            ST_REL: begin
               src <= SRC_NONE;
               if (btn_n) state <= ST_ARM;
            end
            ST_ARM: begin
               if (held[IDX_BTN]) begin
                  state <= ST_BLANK;
                  bcnt  <= '0;
               end
            end
            ST_BLANK: begin
               if (tick) begin
                  if (bcnt == BW'(BLANK_MS - 1)) state <= kill ? ST_ON : ST_REL;
                  else                           bcnt  <= bcnt + 1'b1;
               end
            end
            ST_ON: begin
               fcnt <= '0;
               if (!kill)                state <= ST_REL;
               else if (held[IDX_BTN]) begin
                  state <= ST_REQ;
                  src   <= SRC_BTN;
               end else if (held[IDX_UV]) begin
                  state <= ST_REQ;
                  src   <= SRC_UV;
               end
            end
            ST_REQ: begin
               if (!kill) begin
                  state <= ST_REL;
               end else if (src == SRC_NONE) begin
                  fcnt <= '0;
                  if (held[IDX_BTN])     src <= SRC_BTN;
                  else if (held[IDX_UV]) src <= SRC_UV;
               end else if (!src_low) begin
                  src  <= SRC_NONE;
                  fcnt <= '0;
               end else if (tick) begin
                  if (fcnt + FW'(1) == flim) state <= ST_REL;
                  else                       fcnt  <= fcnt + 1'b1;
               end
            end
            default: state <= ST_REL;
         endcase
      end
   end

   // R4: the blanking window only ends on a millisecond tick
   a_r4_blank_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BLANK && !tick) |=> (state == ST_BLANK));

   // R7: kill low after blanking removes power in the next cycle
   a_r7_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_ON || state == ST_REQ) && !kill) |=> (state == ST_REL));

   // R8: a held button lock is not stolen by the other source
   a_r8_btn_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQ && src == SRC_BTN && !btn_n && kill) |=> (src == SRC_BTN));

   // R8: a held undervoltage lock is not stolen by the button
   a_r8_uv_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQ && src == SRC_UV && !uv_n && kill) |=> (src == SRC_UV));

   // R9: a forced power-off only happens on a tick
   a_r9_force_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REQ && kill && !tick) |=> (state == ST_REQ));

   // R12: no re-arm while the button is still held
   a_r12_rearm: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REL && !btn_n) |=> (state == ST_REL));
endmodule

// File: rtl/pbpwr_seq.sv
module pbpwr_seq
   import pbpwr_pkg::*;
#(
   parameter int CLKS_PER_MS = 100000,
   parameter int DB_MS       = 32,
   parameter int BLANK_MS    = 512,
   parameter int FORCE_MS    = 64,
   parameter int XDLY_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_n,
   input  logic              uv_n,
   input  logic              kill,
   input  logic [XDLY_W-1:0] xdly_ms,
   output logic              irq,
   output logic              pwr_en,
   output logic              pwr_en_n
);
   generate
      if (CLKS_PER_MS < 1) begin : g_bad_clk
         $error("CLKS_PER_MS must be at least 1");
      end
      if (DB_MS < 1) begin : g_bad_db
         $error("DB_MS must be at least 1");
      end
      if (BLANK_MS < 1) begin : g_bad_blank
         $error("BLANK_MS must be at least 1");
      end
      if (FORCE_MS < 1) begin : g_bad_force
         $error("FORCE_MS must be at least 1");
      end
      if (XDLY_W < 1 || XDLY_W > 16) begin : g_bad_xw
         $error("XDLY_W must be between 1 and 16");
      end
   endgenerate

   logic             tick;
   pwr_state_t       state;
   logic [N_SRC-1:0] held;
   logic [N_SRC-1:0] det_en;
   logic [N_SRC-1:0] det_in;

   pbpwr_tick #(.CLKS_PER_MS(CLKS_PER_MS)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick(tick)
   );

   assign det_in[IDX_BTN] = btn_n;
   assign det_in[IDX_UV]  = uv_n;
   assign det_en[IDX_BTN] = (state == ST_ARM) || (state == ST_ON) || (state == ST_REQ);
   assign det_en[IDX_UV]  = (state == ST_ON) || (state == ST_REQ);

   generate
      for (genvar i = 0; i < N_SRC; i++) begin : g_det
         pbpwr_lowdet #(.LIMIT_MS(DB_MS)) u_det (
            .clk(clk), .rst_n(rst_n), .tick(tick),
            .enable(det_en[i]), .sig_n(det_in[i]), .held(held[i])
         );
      end
   endgenerate

   pbpwr_fsm #(
      .BLANK_MS(BLANK_MS), .FORCE_MS(FORCE_MS), .XDLY_W(XDLY_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .btn_n(btn_n), .uv_n(uv_n),
      .kill(kill), .held(held), .xdly_ms(xdly_ms), .state(state)
   );

   assign pwr_en   = (state == ST_BLANK) || (state == ST_ON) || (state == ST_REQ);
   assign pwr_en_n = !pwr_en;
   assign irq      = (state == ST_REQ);

   // R3: power only comes up after the button was seen low
   a_r3_btn_only: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> $past(!btn_n));

   // R6: the interrupt rises only after a completed debounce
   a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(held != '0));

   // R12: the interrupt never outlives power
   a_r12_irq_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> pwr_en);
endmodule

// File: tb/pbpwr_seq_test.sv
`timescale 1ns/1ps
module pbpwr_seq_test;
   localparam int CPM   = 4;
   localparam int DB    = 3;
   localparam int BLANK = 5;
   localparam int FORCE = 4;
   localparam int XW    = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_n = 1'b0;
   logic uv_n = 1'b1;
   logic kill = 1'b0;
   logic [XW-1:0] xdly = '0;
   logic irq, pwr_en, pwr_en_n;

   int checks = 0;
   int fails  = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   pbpwr_seq #(.CLKS_PER_MS(CPM), .DB_MS(DB), .BLANK_MS(BLANK),
               .FORCE_MS(FORCE), .XDLY_W(XW)) uut (
      .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .uv_n(uv_n), .kill(kill),
      .xdly_ms(xdly), .irq(irq), .pwr_en(pwr_en), .pwr_en_n(pwr_en_n)
   );

   // behavioural reference: modes 0 wait-release,1 armed,2 blank,3 on,4 request
   int m_mode, m_lock, m_ph, m_btn_low, m_uv_low, m_blank, m_hold;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_lock = 0; m_ph = 0;
         m_btn_low = 0; m_uv_low = 0; m_blank = 0; m_hold = 0;
      end else begin
         bit ms, bon, uon, bok, uok, lockedlow;
         int nxt;
         ms  = (m_ph == CPM - 1);
         bon = (m_mode == 1) || (m_mode >= 3);
         uon = (m_mode >= 3);
         bok = bon && !btn_n && (m_btn_low >= DB);
         uok = uon && !uv_n && (m_uv_low >= DB);
         lockedlow = (m_lock == 1 && !btn_n) || (m_lock == 2 && !uv_n);
         nxt = m_mode;
         if (m_mode == 0) begin
            m_lock = 0;
            if (btn_n) nxt = 1;
         end else if (m_mode == 1) begin
            if (bok) begin nxt = 2; m_blank = 0; end
         end else if (m_mode == 2) begin
            if (ms) begin
               m_blank++;
               if (m_blank >= BLANK) nxt = kill ? 3 : 0;
            end
         end else if (m_mode == 3) begin
            m_hold = 0;
            if (!kill) nxt = 0;
            else if (bok) begin nxt = 4; m_lock = 1; end
            else if (uok) begin nxt = 4; m_lock = 2; end
         end else begin
            if (!kill) nxt = 0;
            else if (m_lock == 0) begin
               m_hold = 0;
               if (bok) m_lock = 1; else if (uok) m_lock = 2;
            end else if (!lockedlow) begin
               m_lock = 0; m_hold = 0;
            end else if (ms) begin
               m_hold++;
               if (m_hold >= FORCE + int'(xdly)) nxt = 0;
            end
         end
         if (!bon || btn_n) m_btn_low = 0; else if (ms) m_btn_low++;
         if (!uon || uv_n)  m_uv_low  = 0; else if (ms) m_uv_low++;
         m_ph = ms ? 0 : m_ph + 1;
         m_mode = nxt;
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // cycle-by-cycle comparison against the model (R11 polarity included)
   always @(negedge clk) begin
      if (rst_n) begin
         int e_en;
         e_en = (m_mode >= 2) ? 1 : 0;
         chk(cur_req, "pwr_en vs model", int'(pwr_en), e_en);
         chk("R11", "pwr_en_n vs model", int'(pwr_en_n), 1 - e_en);
         chk(cur_req, "irq vs model", int'(irq), (m_mode == 4) ? 1 : 0);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic power_up();
      btn_n = 1'b0; cyc(16);
      btn_n = 1'b1; kill = 1'b1; cyc(30);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      cyc(3);
      // R1: reset values
      chk("R1", "pwr_en in reset", int'(pwr_en), 0);
      chk("R1", "pwr_en_n in reset", int'(pwr_en_n), 1);
      chk("R1", "irq in reset", int'(irq), 0);
      rst_n = 1'b1;
      cyc(1);
      chk("R1", "pwr_en after reset", int'(pwr_en), 0);

      // R12: button held through reset must not power up
      cur_req = "R12";
      cyc(60);
      chk("R12", "held-through-reset pwr_en", int'(pwr_en), 0);
      btn_n = 1'b1; cyc(4);

      // R2: too-short press
      cur_req = "R2";
      btn_n = 1'b0; cyc(8); btn_n = 1'b1; cyc(10);
      chk("R2", "short press pwr_en", int'(pwr_en), 0);

      // R3: undervoltage cannot start power
      cur_req = "R3";
      uv_n = 1'b0; cyc(40);
      chk("R3", "uv low pwr_en", int'(pwr_en), 0);
      uv_n = 1'b1; cyc(2);

      // R2 + R4 + R5: power-on, noise in blank, abort with kill low
      cur_req = "R2";
      btn_n = 1'b0; cyc(20);
      chk("R2", "long press pwr_en", int'(pwr_en), 1);
      btn_n = 1'b1;
      cur_req = "R4";
      uv_n = 1'b0; btn_n = 1'b0; cyc(4);
      uv_n = 1'b1; btn_n = 1'b1;
      chk("R4", "blank ignores inputs irq", int'(irq), 0);
      chk("R4", "blank ignores inputs pwr_en", int'(pwr_en), 1);
      cur_req = "R5";
      cyc(30);
      chk("R5", "abort without kill", int'(pwr_en), 0);

      // R4 + R7: handshake completes, then kill drops power
      cur_req = "R4";
      power_up();
      chk("R4", "on after handshake", int'(pwr_en), 1);
      cur_req = "R7";
      kill = 1'b0; cyc(1);
      chk("R7", "kill low pwr_en", int'(pwr_en), 0);
      cyc(4);

      // R6 + R8: uv request locks, button waits, handover on release
      cur_req = "R6";
      xdly = 4'd15;
      power_up();
      uv_n = 1'b0; cyc(20);
      chk("R6", "uv request irq", int'(irq), 1);
      cur_req = "R8";
      btn_n = 1'b0; cyc(16);
      chk("R8", "second source ignored pwr_en", int'(pwr_en), 1);
      uv_n = 1'b1; cyc(30);
      chk("R8", "handover keeps power", int'(pwr_en), 1);
      chk("R8", "handover keeps irq", int'(irq), 1);
      cur_req = "R7";
      kill = 1'b0; cyc(1);
      chk("R7", "kill low in request pwr_en", int'(pwr_en), 0);
      chk("R12", "irq cleared after off", int'(irq), 0);
      btn_n = 1'b1; cyc(4);

      // R10: forced off with no extra delay
      cur_req = "R10";
      xdly = 4'd0;
      power_up();
      btn_n = 1'b0;
      for (int i = 0; i < 60 && !irq; i++) @(negedge clk);
      chk("R10", "irq before force", int'(irq), 1);
      cyc(12);
      chk("R10", "still on before fixed delay", int'(pwr_en), 1);
      cyc(8);
      chk("R10", "forced off after fixed delay", int'(pwr_en), 0);
      cur_req = "R12";
      cyc(20);
      chk("R12", "held button keeps power off", int'(pwr_en), 0);
      chk("R12", "irq low while off", int'(irq), 0);
      btn_n = 1'b1; kill = 1'b0; cyc(4);

      // R9: forced off with extra delay of 3 ms
      cur_req = "R9";
      xdly = 4'd3;
      power_up();
      uv_n = 1'b0;
      for (int i = 0; i < 60 && !irq; i++) @(negedge clk);
      cyc(20);
      chk("R9", "extra delay keeps power", int'(pwr_en), 1);
      cyc(12);
      chk("R9", "forced off after extra delay", int'(pwr_en), 0);
      uv_n = 1'b1; kill = 1'b0; cyc(8);

      finish_run();
   end
endmodule